// File: doc/BRIEF.md
# Configurable-Frame Serial Receiver with Parity Check

This block turns an asynchronous serial line back into data words. It runs from the system clock. A separate enable, `os_tick_i`, pulses sixteen times per bit period. The receiver passes the line through a synchronizer and looks for a falling edge. It confirms that the start bit is still low half a bit later, then samples every later bit once, at its centre.

The frame shape is chosen at run time. A word has five to eight data bits. The parity slot is absent, even or odd. The frame closes with one or two stop bits. The settings are captured when the start edge is seen, so changing them mid-frame cannot corrupt the word in flight. When the frame completes, the receiver presents the word with a one-clock strobe. A parity-error flag and a framing-error flag go with it. Both flags stay readable until the next start edge.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `valid_o`, `par_err_o`, `frm_err_o` and `data_o` are all zero.
- R2: A frame begins only on a high-to-low transition of the synchronized line. The line is sampled again on the 8th oversampling tick after that edge. If it is high there, the receiver returns to idle and produces no word.
- R3: `len_sel_i` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant bit first. `data_o` is zero above the selected length.
- R4: `par_sel_i` selects parity: 0 is none, 1 is even, 2 is odd and 3 is none. With parity on, the slot directly after the last data bit is the parity bit. Its expected value is the XOR of the data bits for even, and the inverse of that XOR for odd. `par_err_o` is 1 with the word when the received bit differs.
- R5: In no-parity modes no parity slot exists: the bit after the last data bit is a stop bit, and `par_err_o` is 0 with every word.
- R6: `two_stop_i` = 0 expects one stop bit and 1 expects two. `frm_err_o` is 1 with the word if any expected stop bit is sampled low.
- R7: `valid_o` is high for exactly one clock, after the last expected stop bit is sampled. `data_o` and both flags are valid in that clock.
- R8: Both error flags hold their value after the strobe. They are cleared when the next start edge is detected.
- R9: `len_sel_i`, `par_sel_i` and `two_stop_i` are captured at the start edge. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversampling enable, 16 per bit period |
| rx_i | input | 1 | Raw asynchronous serial line |
| len_sel_i | input | 2 | Data length code (5 + value bits) |
| par_sel_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| two_stop_i | input | 1 | 1 selects two stop bits |
| data_o | output | 8 | Received word, zero-extended |
| valid_o | output | 1 | One-clock strobe for a completed word |
| par_err_o | output | 1 | Parity mismatch for the current word |
| frm_err_o | output | 1 | A stop bit was sampled low |

## Verification
Words are sent with every length code, with alternating and single-one bit patterns. These patterns tell a bit-order or length-mask fault apart from a correct word. Each parity mode is tried with a correct parity bit and with an inverted one. Also, a no-parity frame is sent right after a parity frame, which shows whether a parity slot is wrongly inserted. Low stop bits in the first and then the second stop position separate one-stop from two-stop handling. A short low pulse on an idle line checks start-bit validation. A mid-frame change of settings checks the capture at the start edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    par_mode_e  par;
    logic       two_stop;
  } rx_cfg_t;

  localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= din_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], din_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

  p_fall_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> ($past(line_o) && !line_o));
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int unsigned MAX_BITS = 8,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic [MAX_BITS-1:0] word_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                odd_i,
  output logic                exp_o
);
  logic [MAX_BITS-1:0] masked;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign masked[i] = word_i[i] & (LEN_W'(i) < len_i);
  end

  assign exp_o = (^masked) ^ odd_i;
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 8,
  parameter int unsigned OVS      = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_BITS),
  localparam int unsigned CNT_W   = $clog2(OVS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                line_i,
  input  logic                fall_i,
  input  rx_cfg_t             cfg_i,
  input  logic                exp_par_i,
  output logic [LEN_W-1:0]    len_o,
  output logic                odd_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                par_err_o,
  output logic                frm_err_o
);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e           state_q;
  rx_cfg_t             cfg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic                stop2_q;
  logic [MAX_BITS-1:0] data_q;
  logic                valid_q, par_err_q, frm_err_q;
  logic                par_en, last_bit, mid_pt;

  assign len_o    = LEN_W'(cfg_q.len_code) + LEN_W'(MIN_BITS);
  assign odd_o    = (cfg_q.par == PAR_ODD);
  assign par_en   = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
  assign last_bit = (LEN_W'(idx_q) == len_o - LEN_W'(1));
  assign mid_pt   = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      stop2_q   <= 1'b0;
      data_q    <= '0;
      valid_q   <= 1'b0;
      par_err_q <= 1'b0;
      frm_err_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_q   <= ST_START;
            cfg_q     <= cfg_i;
            cnt_q     <= '0;
            idx_q     <= '0;
            stop2_q   <= 1'b0;
            data_q    <= '0;
            par_err_q <= 1'b0;
            frm_err_q <= 1'b0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              state_q <= line_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (mid_pt) begin
              data_q[idx_q] <= line_i;
              if (last_bit) begin
                idx_q   <= '0;
                state_q <= par_en ? ST_PAR : ST_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (mid_pt) begin
              par_err_q <= (line_i != exp_par_i);
              state_q   <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (mid_pt) begin
              if (!line_i) frm_err_q <= 1'b1;
              if (cfg_q.two_stop && !stop2_q) begin
                stop2_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
                valid_q <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign par_err_o = par_err_q;
  assign frm_err_o = frm_err_q;

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (state_q == ST_IDLE));

  p_no_par_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !par_en) |-> !par_err_q);

  p_flags_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) == ST_IDLE) |-> (!par_err_q && !frm_err_q));

  p_data_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(data_q) && state_q != ST_START) |-> $past(tick_i));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS    = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                os_tick_i,
  input  logic                rx_i,
  input  logic [1:0]          len_sel_i,
  input  logic [1:0]          par_sel_i,
  input  logic                two_stop_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                par_err_o,
  output logic                frm_err_o
);
  logic             line_s, fall_s, exp_par;
  logic             odd_sel;
  logic [LEN_W-1:0] len_cur;
  rx_cfg_t          cfg_in;

  assign cfg_in = '{len_code: len_sel_i, par: par_mode_e'(par_sel_i), two_stop: two_stop_i};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (rx_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  uart_rx_parity #(.MAX_BITS(MAX_BITS)) u_par (
    .word_i (data_o),
    .len_i  (len_cur),
    .odd_i  (odd_sel),
    .exp_o  (exp_par)
  );

  uart_rx_ctrl #(.MAX_BITS(MAX_BITS), .OVS(OVS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .line_i    (line_s),
    .fall_i    (fall_s),
    .cfg_i     (cfg_in),
    .exp_par_i (exp_par),
    .len_o     (len_cur),
    .odd_o     (odd_sel),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o)
  );
endmodule

// File: tb/uart_frame_rx_tb_top.sv
module uart_frame_rx_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic [1:0] len_sel = 2'd3, par_sel = 2'd0;
  logic two_stop = 1'b0;
  logic [7:0] data;
  logic valid, perr, ferr;

  int errors = 0, checks = 0, n_valid = 0, tdiv = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  uart_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx),
    .len_sel_i(len_sel), .par_sel_i(par_sel), .two_stop_i(two_stop),
    .data_o(data), .valid_o(valid), .par_err_o(perr), .frm_err_o(ferr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      exp_t e, a;
      n_valid++;
      a = '{data, perr, ferr};
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected word", int'(a), 0);
      end else begin
        e = q.pop_front();
        check(a == e, "R3/R4/R5/R6/R7/R9 word", int'(a), int'(e));
      end
    end
  end

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic [1:0] pm,
                      input logic ts, input bit bad_par, input bit bad_s0, input bit bad_s1,
                      input bit mid_change);
    int n;
    logic [7:0] dm;
    logic pbit;
    bit pen;
    n   = 5 + int'(len);
    dm  = d & 8'((1 << n) - 1);
    pen = (pm == 2'd1) || (pm == 2'd2);
    pbit = (^dm) ^ (pm == 2'd2);
    q.push_back('{dm, pen && bad_par, bad_s0 || (ts && bad_s1)});
    len_sel = len; par_sel = pm; two_stop = ts;
    drive_bit(1'b0);
    if (mid_change) begin
      len_sel = ~len; par_sel = (pm == 2'd0) ? 2'd1 : 2'd0; two_stop = ~ts;
    end
    for (int i = 0; i < n; i++) drive_bit(dm[i]);
    if (pen) drive_bit(bad_par ? ~pbit : pbit);
    drive_bit(bad_s0 ? 1'b0 : 1'b1);
    if (ts) drive_bit(bad_s1 ? 1'b0 : 1'b1);
    rx = 1'b1;
    repeat (BIT_CLKS / 2) @(negedge clk);
  endtask

  initial begin
    int nv;
    repeat (5) @(negedge clk);
    check(valid == 0 && perr == 0 && ferr == 0 && data == 0, "R1 reset", {data, valid, perr, ferr}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(valid == 0 && data == 0, "R1 idle after reset", {data, valid}, 0);

    // R3 lengths, no parity
    send(8'hA5, 2'd3, 2'd0, 1'b0, 0, 0, 0, 0);
    send(8'hFF, 2'd0, 2'd0, 1'b0, 0, 0, 0, 0);
    send(8'h2A, 2'd1, 2'd0, 1'b0, 0, 0, 0, 0);
    send(8'h41, 2'd2, 2'd0, 1'b0, 0, 0, 0, 0);
    // R4 parity, even and odd, good and bad
    send(8'h29, 2'd3, 2'd1, 1'b0, 0, 0, 0, 0);
    send(8'h29, 2'd3, 2'd1, 1'b0, 1, 0, 0, 0);
    send(8'h15, 2'd0, 2'd2, 1'b0, 0, 0, 0, 0);
    send(8'h3C, 2'd1, 2'd2, 1'b1, 1, 0, 0, 0);
    // R5 no parity after parity frame; mode 3 is none
    send(8'h80, 2'd3, 2'd0, 1'b0, 1, 0, 0, 0);
    send(8'h55, 2'd3, 2'd3, 1'b0, 1, 0, 0, 0);
    // R6 stop errors
    send(8'h12, 2'd3, 2'd0, 1'b0, 0, 1, 0, 0);
    send(8'h34, 2'd3, 2'd1, 1'b1, 0, 0, 1, 0);
    send(8'h56, 2'd2, 2'd2, 1'b1, 0, 1, 0, 0);

    // R8 flags cleared at next start edge
    send(8'h77, 2'd3, 2'd1, 1'b0, 1, 1, 0, 0);
    check(perr && ferr, "R8 flags held", {perr, ferr}, 3);
    fork
      send(8'h01, 2'd3, 2'd0, 1'b0, 0, 0, 0, 0);
      begin
        repeat (BIT_CLKS) @(negedge clk);
        check(!perr && !ferr, "R8 flags cleared", {perr, ferr}, 0);
      end
    join

    // R2 glitch rejected
    nv = n_valid;
    rx = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check(n_valid == nv, "R2 glitch ignored", n_valid, nv);
    send(8'hC3, 2'd3, 2'd1, 1'b0, 0, 0, 0, 0);

    // R9 config change mid frame
    send(8'hB6, 2'd3, 2'd1, 1'b1, 0, 0, 0, 1);
    send(8'h0B, 2'd0, 2'd0, 1'b0, 0, 0, 0, 1);

    repeat (BIT_CLKS) @(negedge clk);
    check(q.size() == 0, "R7 all words delivered", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule